// File: doc/BRIEF.md
# Vector Length Setting Unit

This block keeps the current vector length (VL) and the maximum vector length (MVL) of a vector-capable core. It takes a 12-bit length-control field from a long-form prefixed instruction, together with a valid strobe, the value of the scalar register the field points at, and a strap that says whether length control is supported. It then updates VL and MVL. It can also ask the register file to write the new VL back into a scalar register.

Layout of the field: bit 11 selects the mode family, bits 10:6 give the write-back register index, bits 5:1 hold a 5-bit immediate or a source register index, and bit 0 picks the sub-mode. An all-zero field leaves every register as it is. Family 0 is a loop-style set of VL, either from the immediate or from a register. Family 1 is a one-off set of MVL, which either copies the new value into VL or clamps VL to it. All results appear one clock after the strobe.

Top module: `vlen_ctrl`

## Requirements
- R1: While reset is held and after it is released, VL and MVL are both 1, and neither write-back nor illegal is asserted.
- R2: A strobe with a field of all zeros changes neither VL nor MVL and raises neither write-back nor illegal, whatever the strap.
- R3: With bit 11 = 0 and bit 0 = 0, VL becomes bits 5:1 plus one (code 0 gives 1). MVL is unchanged, and VL is not clamped to MVL.
- R4: With bit 11 = 0, bit 0 = 1 and a nonzero index in bits 5:1, VL becomes the supplied register value if that value is at most MVL, and MVL otherwise. MVL is unchanged.
- R5: With bit 11 = 0, bit 0 = 1 and index 0 in bits 5:1, the illegal flag rises, VL and MVL keep their values, and no write-back occurs.
- R6: With bit 11 = 1 and bit 0 = 0, MVL and VL both become bits 5:1 plus one.
- R7: With bit 11 = 1 and bit 0 = 1, MVL becomes bits 5:1 plus one. VL becomes the smaller of its old value and the new MVL.
- R8: After a legal nonzero field, a write-back request carries index bits 10:6 and the new VL, zero-extended. Index 0 suppresses the request.
- R9: With the strap low, any nonzero field raises illegal, leaves VL and MVL unchanged and requests no write-back.
- R10: Every update, write-back request and illegal flag appears on the clock edge after the strobe. Write-back and illegal each last exactly one cycle when the strobe is single.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Field strobe |
| vlTyp | input | 12 | Length-control field |
| srcRegVal | input | XLEN | Value of the scalar register named by bits 5:1 |
| vlTypEn | input | 1 | Strap: length control supported |
| vl | output | LEN_W | Current vector length |
| mvl | output | LEN_W | Current maximum vector length |
| wbValid | output | 1 | Scalar write-back request |
| wbIdx | output | 5 | Write-back register index |
| wbData | output | XLEN | Write-back value (new VL) |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
Two things can happen on the same edge: the clamp of VL to a lowered MVL, and the write-back of the result. The sequence that provokes this first raises VL to several preset values, then sweeps every immediate of the clamp-on-MVL mode with a nonzero destination. The bench then checks that the write-back value equals the clamped VL and not the old VL or the new MVL. The register-sourced mode is swept in the same way against several MVL values, so that the clamp and the write-back again share an edge.

// File: rtl/vlen_ctrl_pkg.sv
package vlen_ctrl_pkg;
  localparam int FIELD_W = 12;
  localparam int IDX_W   = 5;

  typedef enum logic [1:0] {
    VL_KEEP = 2'd0,
    VL_IMM  = 2'd1,
    VL_REG  = 2'd2,
    VL_MIN  = 2'd3
  } vlSrc_e;

  typedef struct packed {
    logic   wrMvl;
    vlSrc_e vlSrc;
    logic   wbReq;
    logic   illegal;
  } vlCtrl_t;
endpackage

// File: rtl/vlen_ctrl_decode.sv
module vlen_ctrl_decode
  import vlen_ctrl_pkg::*;
(
  input  logic               inValid,
  input  logic [FIELD_W-1:0] vlTyp,
  input  logic               vlTypEn,
  output vlCtrl_t            ctrl
);
  logic             famOneShot;
  logic             subSel;
  logic [IDX_W-1:0] immIdx;
  logic [IDX_W-1:0] destIdx;

  assign famOneShot = vlTyp[FIELD_W-1];
  assign subSel     = vlTyp[0];
  assign immIdx     = vlTyp[IDX_W:1];
  assign destIdx    = vlTyp[FIELD_W-2:IDX_W+1];

  always_comb begin
    ctrl         = '0;
    ctrl.vlSrc   = VL_KEEP;
    if (inValid && (vlTyp != '0)) begin
      if (!vlTypEn) begin
        ctrl.illegal = 1'b1;
      end else begin
        unique case ({famOneShot, subSel})
          2'b00: ctrl.vlSrc = VL_IMM;
          2'b01: begin
            if (immIdx == '0) ctrl.illegal = 1'b1;
            else              ctrl.vlSrc   = VL_REG;
          end
          2'b10: begin
            ctrl.wrMvl = 1'b1;
            ctrl.vlSrc = VL_IMM;
          end
          default: begin
            ctrl.wrMvl = 1'b1;
            ctrl.vlSrc = VL_MIN;
          end
        endcase
        ctrl.wbReq = !ctrl.illegal && (destIdx != '0);
      end
    end
  end
endmodule

// File: rtl/vlen_ctrl_dp.sv
module vlen_ctrl_dp
  import vlen_ctrl_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  vlCtrl_t          ctrl,
  input  logic [IDX_W-1:0] immIdx,
  input  logic [IDX_W-1:0] destIdx,
  input  logic [XLEN-1:0]  srcRegVal,
  output logic [LEN_W-1:0] vl,
  output logic [LEN_W-1:0] mvl,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbIdx,
  output logic [XLEN-1:0]  wbData,
  output logic             illegal
);
  localparam int PAD_W = XLEN - LEN_W;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] vlQ, mvlQ;
  logic [LEN_W-1:0] immPlus;
  logic [LEN_W-1:0] regClamp;
  logic [LEN_W-1:0] minOld;
  logic [LEN_W-1:0] nextVl;
  logic [LEN_W-1:0] nextMvl;

  assign immPlus  = LEN_W'(immIdx) + ONE;
  assign regClamp = (srcRegVal > {{PAD_W{1'b0}}, mvlQ}) ? mvlQ
                                                        : srcRegVal[LEN_W-1:0];
  assign minOld   = (vlQ > immPlus) ? immPlus : vlQ;

  always_comb begin
    unique case (ctrl.vlSrc)
      VL_IMM:  nextVl = immPlus;
      VL_REG:  nextVl = regClamp;
      VL_MIN:  nextVl = minOld;
      default: nextVl = vlQ;
    endcase
    nextMvl = ctrl.wrMvl ? immPlus : mvlQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlQ     <= ONE;
      mvlQ    <= ONE;
      wbValid <= 1'b0;
      wbIdx   <= '0;
      wbData  <= '0;
      illegal <= 1'b0;
    end else begin
      vlQ     <= nextVl;
      mvlQ    <= nextMvl;
      wbValid <= ctrl.wbReq;
      illegal <= ctrl.illegal;
      if (ctrl.wbReq) begin
        wbIdx  <= destIdx;
        wbData <= {{PAD_W{1'b0}}, nextVl};
      end
    end
  end

  assign vl  = vlQ;
  assign mvl = mvlQ;
endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_ctrl_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LEN_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [FIELD_W-1:0] vlTyp,
  input  logic [XLEN-1:0]    srcRegVal,
  input  logic               vlTypEn,
  output logic [LEN_W-1:0]   vl,
  output logic [LEN_W-1:0]   mvl,
  output logic               wbValid,
  output logic [IDX_W-1:0]   wbIdx,
  output logic [XLEN-1:0]    wbData,
  output logic               illegal
);
  vlCtrl_t ctrl;

  vlen_ctrl_decode decode_i (
    .inValid (inValid),
    .vlTyp   (vlTyp),
    .vlTypEn (vlTypEn),
    .ctrl    (ctrl)
  );

  vlen_ctrl_dp #(.XLEN(XLEN), .LEN_W(LEN_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .immIdx    (vlTyp[IDX_W:1]),
    .destIdx   (vlTyp[FIELD_W-2:IDX_W+1]),
    .srcRegVal (srcRegVal),
    .vl        (vl),
    .mvl       (mvl),
    .wbValid   (wbValid),
    .wbIdx     (wbIdx),
    .wbData    (wbData),
    .illegal   (illegal)
  );
endmodule

// File: rtl/vlen_ctrl_chk.sv
module vlen_ctrl_chk
  import vlen_ctrl_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LEN_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [FIELD_W-1:0] vlTyp,
  input logic               vlTypEn,
  input logic [LEN_W-1:0]   vl,
  input logic [LEN_W-1:0]   mvl,
  input logic               wbValid,
  input logic [IDX_W-1:0]   wbIdx,
  input logic [XLEN-1:0]    wbData,
  input logic               illegal
);
  // R2
  zero_field_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vlTyp == '0) |=> (!wbValid && !illegal && $stable(vl) && $stable(mvl)));

  // R5
  reg_x0_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vlTypEn && !vlTyp[11] && vlTyp[0] && vlTyp[5:1] == '0)
      |=> (illegal && !wbValid));

  // R7
  clamp_within_mvl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vlTypEn && vlTyp[11] && vlTyp[0]) |=> (vl <= mvl));

  // R8
  wb_not_x0_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbIdx != '0 && wbData == XLEN'(vl)));

  // R9
  illegal_holds_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> ($stable(vl) && $stable(mvl) && !wbValid));

  // R10
  wb_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid || illegal) |-> $past(inValid));
endmodule

bind vlen_ctrl vlen_ctrl_chk #(.XLEN(XLEN), .LEN_W(LEN_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .vlTyp   (vlTyp),
  .vlTypEn (vlTypEn),
  .vl      (vl),
  .mvl     (mvl),
  .wbValid (wbValid),
  .wbIdx   (wbIdx),
  .wbData  (wbData),
  .illegal (illegal)
);

// File: tb/vlen_ctrl_tb_top.sv
module vlen_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 32;
  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [11:0]      vlTyp = '0;
  logic [XLEN-1:0]  srcRegVal = '0;
  logic             vlTypEn = 1'b1;
  logic [LEN_W-1:0] vl, mvl;
  logic             wbValid;
  logic [4:0]       wbIdx;
  logic [XLEN-1:0]  wbData;
  logic             illegal;

  int checks = 0;
  int errors = 0;
  int expVl = 1;
  int expMvl = 1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlen_ctrl #(.XLEN(XLEN), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .vlTyp(vlTyp),
    .srcRegVal(srcRegVal), .vlTypEn(vlTypEn), .vl(vl), .mvl(mvl),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData), .illegal(illegal)
  );

  task automatic checkEq(input string tag, input string what,
                         input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input int fam, input int dest,
                                     input int imm, input int sub);
    return {fam[0], dest[4:0], imm[4:0], sub[0]};
  endfunction

  task automatic doOp(input logic [11:0] f, input logic [31:0] rv,
                      input logic en, input string tag);
    int  imm, dest;
    bit  ill;
    longint newVl, newMvl;
    imm = int'(f[5:1]);
    dest = int'(f[10:6]);
    ill = 0;
    newVl = expVl;
    newMvl = expMvl;
    if (f != 0) begin
      if (!en) ill = 1;
      else if (!f[11] && !f[0]) newVl = imm + 1;
      else if (!f[11] && f[0]) begin
        if (imm == 0) ill = 1;
        else newVl = (longint'(rv) > expMvl) ? expMvl : longint'(rv);
      end else if (f[11] && !f[0]) begin
        newMvl = imm + 1; newVl = imm + 1;
      end else begin
        newMvl = imm + 1;
        newVl = (expVl > imm + 1) ? imm + 1 : expVl;
      end
    end
    @(negedge clk);
    vlTyp = f; srcRegVal = rv; vlTypEn = en; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; vlTyp = '0;
    checkEq(tag, "vl", vl, newVl);
    checkEq(tag, "mvl", mvl, newMvl);
    checkEq(tag, "illegal", illegal, ill);
    checkEq(tag, "wbValid", wbValid, (!ill && f != 0 && dest != 0));
    if (!ill && f != 0 && dest != 0) begin
      checkEq(tag, "wbIdx", wbIdx, dest);
      checkEq(tag, "wbData", wbData, newVl);
    end
    expVl = int'(newVl);
    expMvl = int'(newMvl);
    @(negedge clk);
    checkEq("R10", "wbValid pulse end", wbValid, 0);
    checkEq("R10", "illegal pulse end", illegal, 0);
  endtask

  initial begin
    int presets[3];
    int mvls[3];
    presets = '{1, 10, 32};
    mvls = '{1, 7, 32};
    repeat (3) @(negedge clk);
    checkEq("R1", "vl in reset", vl, 1);
    checkEq("R1", "mvl in reset", mvl, 1);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "vl after reset", vl, 1);
    checkEq("R1", "mvl after reset", mvl, 1);
    checkEq("R1", "wbValid after reset", wbValid, 0);
    checkEq("R1", "illegal after reset", illegal, 0);

    doOp(12'h000, 32'd9, 1'b1, "R2");
    doOp(12'h000, 32'd9, 1'b0, "R2");

    for (int i = 0; i < 32; i++) doOp(mk(1, i, i, 0), 0, 1'b1, "R6");

    doOp(mk(1, 3, 3, 0), 0, 1'b1, "R6");
    for (int i = 0; i < 32; i++) doOp(mk(0, 31 - i, i, 0), 0, 1'b1, "R3");

    foreach (mvls[k]) begin
      doOp(mk(1, 0, mvls[k] - 1, 0), 0, 1'b1, "R6");
      for (int v = 0; v < 41; v++) doOp(mk(0, 5, 1 + (v % 31), 1), v, 1'b1, "R4");
      doOp(mk(0, 6, 2, 1), 32'hFFFF_FFFF, 1'b1, "R4");
      doOp(mk(0, 7, 0, 1), 32'd3, 1'b1, "R5");
      doOp(mk(0, 0, 0, 1), 32'd0, 1'b1, "R5");
    end

    foreach (presets[k]) begin
      for (int i = 0; i < 32; i++) begin
        doOp(mk(1, 0, 31, 0), 0, 1'b1, "R7");
        doOp(mk(0, 0, presets[k] - 1, 0), 0, 1'b1, "R7");
        doOp(mk(1, 1 + (i % 31), i, 1), 0, 1'b1, "R7");
      end
    end

    doOp(mk(1, 4, 8, 1), 0, 1'b1, "R8");
    doOp(mk(0, 0, 8, 0), 0, 1'b1, "R8");

    for (int i = 1; i < 4096; i += 97) doOp(12'(i), 32'd5, 1'b0, "R9");
    doOp(12'hFFF, 32'd5, 1'b0, "R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule